// File: doc/BRIEF.md
# Gated Periodic Rate Generator

This block is a programmable divide-by-N tick source. Software writes an initial count N. From then on the output rests high and dips low for exactly one clock once every N clocks. This suits periodic tick interrupts. A level-sensitive enable input freezes the down-counter while it is low. A low-to-high transition on that input restarts the current period, so external logic can bring the tick phase into line with an event.

A count written while the generator is running does not cut the period in progress short. The new value takes effect when the current period wraps, or at a restart, whichever comes first. A count of 1 cannot produce a one-clock-low pattern and is rejected. A count of 0 stands for the largest period, 2^CNT_W clocks. Counting is binary only, and there is a single fixed behaviour.

Top module: `rate_tick_gen`

## Requirements
- R1: After reset, and for as long as no accepted count has been written, out_o is held high whatever gate_i does.
- R2: An accepted write sampled on clock edge 0 loads the counter on edge 1. out_o first goes low in the cycle after edge N and stays high before that.
- R3: In steady counting with gate_i high, out_o is low for exactly one clock per period. The low cycles are spaced exactly N clocks apart, indefinitely.
- R4: While gate_i is low, out_o is high in that same cycle without waiting for a clock, and the counter holds its value.
- R5: A low-to-high change of gate_i sampled on edge t reloads the counter on edge t+1. The next low cycle of out_o follows edge t+N, and the period then repeats every N clocks.
- R6: A count written while counting leaves the current period unchanged. If the first low follows edge P, the next period uses the new count M, and its low follows edge P+M.
- R7: If a restart on gate_i arrives after a new count was written but before the period ends, the restart loads the new count.
- R8: A write of value 1 is ignored. An already running sequence keeps its count and phase, and an idle block stays idle with out_o high.
- R9: A written value of 0 selects a period of 2^CNT_W clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| gate_i | input | 1 | Count enable; a rising transition restarts the period |
| wr_i | input | 1 | Strobe that writes wr_count_i as the new count |
| wr_count_i | input | CNT_W | Count value; 0 means 2^CNT_W, 1 is rejected |
| out_o | output | 1 | Tick output, low for one clock per period |

## Verification
The bench builds the generator with CNT_W = 4. At that width every legal count, from 2 up to 16 (written as 0), can be swept through several full periods and each cycle compared with an arithmetic schedule of low cycles. The small width also makes the wrap case for the zero encoding reachable in a few dozen clocks. It runs short directed sequences for the gate freeze and restart, for a count change in mid-period with and without a restart, and for the rejected value.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    // Sequencing of the down-counter
    typedef enum logic [1:0] {
        RTG_IDLE = 2'd0,   // no accepted count yet
        RTG_LOAD = 2'd1,   // load reload value on the next edge
        RTG_RUN  = 2'd2    // counting
    } rtg_state_e;

    // Control events presented to the down-counter
    typedef struct packed {
        logic accept;      // a legal count was written this cycle
        logic restart;     // gate transitioned low-to-high
    } rtg_evt_t;

endpackage

// File: rtl/rtg_edge_detect.sv
module rtg_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    output logic rise_o
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_i;
    end

    assign rise_o = gate_i & ~gate_q;

endmodule

// File: rtl/rtg_count_store.sv
module rtg_count_store #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_count_i,
    output logic             accept_o,
    output logic [CNT_W:0]   reload_o
);
    localparam int VAL_W = CNT_W + 1;
    localparam logic [VAL_W-1:0] FULL_PERIOD = VAL_W'(1) << CNT_W;
    localparam logic [CNT_W-1:0] BAD_VALUE   = CNT_W'(1);

    logic [VAL_W-1:0] reload_q;

    assign accept_o = wr_i && (wr_count_i != BAD_VALUE);

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (accept_o) begin
            reload_q <= (wr_count_i == '0) ? FULL_PERIOD : {1'b0, wr_count_i};
        end
    end

    assign reload_o = reload_q;

    // R8
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i && wr_count_i == BAD_VALUE) |=> $stable(reload_q));

endmodule

// File: rtl/rtg_downcounter.sv
module rtg_downcounter
    import rtg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_i,
    input  rtg_evt_t         evt_i,
    input  logic [CNT_W:0]   reload_i,
    output rtg_state_e       state_o,
    output logic [CNT_W:0]   cnt_o
);
    localparam int VAL_W = CNT_W + 1;
    localparam logic [VAL_W-1:0] LAST = VAL_W'(1);

    rtg_state_e       state_q;
    logic [VAL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RTG_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                RTG_IDLE: begin
                    if (evt_i.accept) state_q <= RTG_LOAD;
                end
                RTG_LOAD: begin
                    cnt_q   <= reload_i;
                    state_q <= evt_i.restart ? RTG_LOAD : RTG_RUN;
                end
                RTG_RUN: begin
                    if (evt_i.restart) state_q <= RTG_LOAD;
                    if (gate_i) begin
                        cnt_q <= (cnt_q == LAST) ? reload_i : cnt_q - LAST;
                    end
                end
                default: state_q <= RTG_IDLE;
            endcase
        end
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RTG_LOAD) |=> (cnt_q == $past(reload_i)));

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RTG_RUN && !gate_i) |=> $stable(cnt_q));

    // R3
    run_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == RTG_LOAD) |=> (cnt_q >= VAL_W'(2)));

endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
    import rtg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wr_count_i,
    output logic             out_o
);
    localparam int VAL_W = CNT_W + 1;

    logic             rise;
    logic             accept;
    logic [VAL_W-1:0] reload;
    logic [VAL_W-1:0] cnt;
    rtg_state_e       state;
    rtg_evt_t         evt;

    rtg_edge_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .gate_i (gate_i),
        .rise_o (rise)
    );

    rtg_count_store #(.CNT_W(CNT_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (wr_i),
        .wr_count_i (wr_count_i),
        .accept_o   (accept),
        .reload_o   (reload)
    );

    always_comb begin
        evt.accept  = accept;
        evt.restart = rise && (state != RTG_IDLE);
    end

    rtg_downcounter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .gate_i   (gate_i),
        .evt_i    (evt),
        .reload_i (reload),
        .state_o  (state),
        .cnt_o    (cnt)
    );

    // Low only on the terminal count of a running, enabled, non-restarting period
    assign out_o = ~((state == RTG_RUN) && (cnt == VAL_W'(1)) && gate_i && !rise);

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !out_o |=> out_o);

    // R4
    gate_low_high_chk: assert property (@(posedge clk) disable iff (rst)
        !gate_i |-> out_o);

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RTG_IDLE) |-> out_o);

endmodule

// File: tb/tb_rate_tick_gen.sv
module tb_rate_tick_gen;
    localparam int CNT_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gate_i = 1'b1;
    logic             wr_i = 1'b0;
    logic [CNT_W-1:0] wr_count_i = '0;
    logic             out_o;

    int checks = 0;
    int errors = 0;

    rate_tick_gen #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .gate_i(gate_i),
        .wr_i(wr_i), .wr_count_i(wr_count_i), .out_o(out_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int k, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d out_o actual %b expected %b", req, k, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; gate_i = 1'b1; wr_i = 1'b0; wr_count_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Drives a write at the current negedge; returns at the negedge after edge 0
    task automatic do_write(input int n);
        wr_i = 1'b1; wr_count_i = CNT_W'(n);
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and idle with gate activity
        do_reset();
        chk("R1", 0, out_o, 1'b1);
        for (int k = 1; k <= 10; k++) begin
            gate_i = k[0];
            @(negedge clk);
            chk("R1", k, out_o, 1'b1);
        end
        gate_i = 1'b1;

        // R8: illegal count from idle keeps block idle
        do_write(1);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk("R8", k, out_o, 1'b1);
        end

        // R2 R3 R9: sweep every legal count (16 written as 0)
        for (int n = 2; n <= 16; n++) begin
            do_reset();
            do_write(n);
            chk("R2", 0, out_o, 1'b1);
            for (int k = 1; k <= 3 * n + 1; k++) begin
                @(negedge clk);
                chk(n == 16 ? "R9" : (k <= n ? "R2" : "R3"), k, out_o,
                    !((k >= n) && ((k - n) % n == 0)));
            end
        end

        // R4 R5: gate low during the low cycle, then restart
        do_reset();
        do_write(5);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (k <= 5) chk(k == 5 ? "R3" : "R2", k, out_o, k != 5);
            if (k == 5) begin
                gate_i = 1'b0; #1;
                chk("R4", k, out_o, 1'b1);
            end else if (k > 5 && k < 8) begin
                chk("R4", k, out_o, 1'b1);
            end else if (k == 8) begin
                chk("R4", k, out_o, 1'b1);
                gate_i = 1'b1; #1;
                chk("R5", k, out_o, 1'b1);
            end else if (k > 8) begin
                chk("R5", k, out_o, !(k == 14 || k == 19));
            end
        end

        // R6: new count mid-period applies at period end
        do_reset();
        do_write(5);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            chk("R6", k, out_o, !(k == 5 || k == 12 || k == 19));
            if (k == 2) begin wr_i = 1'b1; wr_count_i = CNT_W'(7); end
            else wr_i = 1'b0;
        end

        // R7: new count then restart before period end
        do_reset();
        do_write(8);
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            chk("R7", k, out_o, !(k == 9 || k == 13));
            wr_i = (k == 2);
            if (k == 2) wr_count_i = CNT_W'(4);
            if (k == 3) gate_i = 1'b0;
            if (k == 4) gate_i = 1'b1;
        end

        // R8: illegal count while running leaves phase and period alone
        do_reset();
        do_write(5);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            chk("R8", k, out_o, !(k == 5 || k == 10 || k == 15));
            wr_i = (k == 1 || k == 7);
            wr_count_i = CNT_W'(1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule